// File: doc/BRIEF.md
# State-Change Side-Effect Checker

This block sits beside a sequential engine and watches a vector of its internal storage bits. Each time the engine completes an operation, the caller strobes the new storage snapshot together with a mask of the bits that operation is supposed to flip. The checker XORs the snapshot with the one held from the previous operation. The result is the set of bits that actually toggled. It compares that set with the intended one.

The verdict is reported one cycle later. A fault flag is raised whenever the toggled set differs from the intended set. A second flag marks the narrower case where every intended toggle happened and extra bits moved as well. A mask lists the bits that toggled without being asked to. Two saturating counters keep running totals of faults and of these extra-only faults. Only storage bits are fed in. Primary outputs are checked elsewhere, because they can be observed directly.

Top module: `state_delta_checker`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `out_valid`, `out_fault`, `out_pure`, `out_extra`, `fault_count` and `pure_count` are all zero.
- R2: The first `in_valid` sample after reset only records `in_state` as the reference snapshot. One cycle later `out_valid` stays low and no flag or counter changes.
- R3: Every later `in_valid` sample forms the observed toggle mask as `in_state` XOR the snapshot from the previous valid sample. It then replaces that snapshot with `in_state`.
- R4: One cycle after a judged sample, `out_valid` is 1. `out_fault` is 1 exactly when the observed toggle mask differs from `in_expect`.
- R5: `out_pure` is 1 only when `out_fault` is 1 and every bit set in `in_expect` is also set in the observed mask. If an intended bit failed to toggle, `out_fault` is 1 and `out_pure` is 0.
- R6: `out_extra` equals observed AND NOT `in_expect`, registered with the verdict. A single extra toggled bit appears as a one-hot mask with `out_fault` high.
- R7: `fault_count` rises by one in the same cycle that `out_fault` is reported. It stops at 2^CNT_W-1 and stays there while further faults are still flagged.
- R8: `pure_count` rises by one in the same cycle that `out_pure` is reported. It saturates at 2^CNT_W-1.
- R9: In a cycle after `in_valid` was low, `out_valid`, `out_fault`, `out_pure` and `out_extra` are zero. In that idle case `in_state` is ignored and the reference snapshot is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a completed operation |
| in_state | input | STATE_W | Storage snapshot after the operation |
| in_expect | input | STATE_W | Bits the operation should toggle |
| out_valid | output | 1 | A verdict is present this cycle |
| out_fault | output | 1 | Observed toggles differ from intended |
| out_pure | output | 1 | Fault made only of extra toggles |
| out_extra | output | STATE_W | Bits toggled without being intended |
| fault_count | output | CNT_W | Saturating fault total |
| pure_count | output | CNT_W | Saturating extra-only fault total |

## Verification
The fault verdict and the saturation of the fault counter can land on the same edge. The question is whether a fault flagged on the edge where the count pins at its maximum is still reported. The bench provokes this by issuing an unbroken run of one-extra-bit operations, more than 2^16 of them back to back, which drives both counters to their ceiling. It then judges that the last verdict still carries `out_fault`, `out_pure` and the one-hot mask, while both counts read all ones rather than wrapping.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic {
    PH_EMPTY  = 1'b0,
    PH_PRIMED = 1'b1
  } ref_phase_t;
endpackage

// File: rtl/sdc_snapshot.sv
module sdc_snapshot #(
  parameter int STATE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_valid,
  input  logic [STATE_W-1:0] smp_state,
  output logic [STATE_W-1:0] toggled,
  output logic               have_ref
);
  import sdc_pkg::*;

  ref_phase_t         phase_q;
  logic [STATE_W-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_EMPTY;
      ref_q   <= '0;
    end else if (smp_valid) begin
      phase_q <= PH_PRIMED;
      ref_q   <= smp_state;
    end
  end

  assign toggled  = smp_state ^ ref_q;
  assign have_ref = (phase_q == PH_PRIMED);

  AST_REF_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(ref_q)); // R9
endmodule

// File: rtl/sdc_judge.sv
module sdc_judge #(
  parameter int STATE_W = 16
) (
  input  logic [STATE_W-1:0] seen,
  input  logic [STATE_W-1:0] wanted,
  output logic               mismatch,
  output logic               extra_only,
  output logic [STATE_W-1:0] extra_bits
);
  logic [STATE_W-1:0] missing_bits;

  always_comb begin
    extra_bits   = seen & ~wanted;
    missing_bits = wanted & ~seen;
    mismatch     = (seen != wanted);
    extra_only   = mismatch && (missing_bits == '0);
  end
endmodule

// File: rtl/sdc_sat_counter.sv
module sdc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                      value <= '0;
    else if (bump && value != TOP) value <= value + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bump && value != TOP) |=> (value == $past(value) + 1'b1)); // R7
  AST_CNT_PINNED: assert property (@(posedge clk) disable iff (rst)
    (value == TOP) |=> (value == TOP)); // R7
endmodule

// File: rtl/state_delta_checker.sv
module state_delta_checker #(
  parameter int STATE_W = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [STATE_W-1:0] in_state,
  input  logic [STATE_W-1:0] in_expect,
  output logic               out_valid,
  output logic               out_fault,
  output logic               out_pure,
  output logic [STATE_W-1:0] out_extra,
  output logic [CNT_W-1:0]   fault_count,
  output logic [CNT_W-1:0]   pure_count
);
  logic [STATE_W-1:0] toggled;
  logic               have_ref;
  logic               mismatch, extra_only;
  logic [STATE_W-1:0] extra_bits;
  logic               judged;

  logic               valid_q, fault_q, pure_q;
  logic [STATE_W-1:0] extra_q;

  sdc_snapshot #(.STATE_W(STATE_W)) u_snap (
    .clk(clk), .rst(rst),
    .smp_valid(in_valid), .smp_state(in_state),
    .toggled(toggled), .have_ref(have_ref)
  );

  sdc_judge #(.STATE_W(STATE_W)) u_judge (
    .seen(toggled), .wanted(in_expect),
    .mismatch(mismatch), .extra_only(extra_only), .extra_bits(extra_bits)
  );

  assign judged = in_valid && have_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      pure_q  <= 1'b0;
      extra_q <= '0;
    end else begin
      valid_q <= judged;
      fault_q <= judged && mismatch;
      pure_q  <= judged && extra_only;
      extra_q <= judged ? extra_bits : '0;
    end
  end

  sdc_sat_counter #(.W(CNT_W)) u_fault_cnt (
    .clk(clk), .rst(rst), .bump(judged && mismatch), .value(fault_count)
  );

  sdc_sat_counter #(.W(CNT_W)) u_pure_cnt (
    .clk(clk), .rst(rst), .bump(judged && extra_only), .value(pure_count)
  );

  assign out_valid = valid_q;
  assign out_fault = fault_q;
  assign out_pure  = pure_q;
  assign out_extra = extra_q;

  AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (rst)
    (have_ref && !$past(have_ref)) |-> !valid_q); // R2
  AST_PURE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
    pure_q |-> fault_q); // R5
  AST_EXTRA_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
    (extra_q != '0) |-> fault_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !valid_q |-> (!fault_q && !pure_q && extra_q == '0)); // R9
  AST_PURE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pure_count <= fault_count); // R8
endmodule

// File: tb/tb_state_delta_checker.sv
module tb_state_delta_checker;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst;
  logic          in_valid;
  logic [SW-1:0] in_state, in_expect;
  logic          out_valid, out_fault, out_pure;
  logic [SW-1:0] out_extra;
  logic [CW-1:0] fault_count, pure_count;

  int checks = 0;
  int errors = 0;

  logic [SW-1:0] m_ref;
  bit            m_primed;
  int            m_fcnt, m_pcnt;

  always #2.5 clk = ~clk;

  state_delta_checker #(.STATE_W(SW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_state(in_state),
    .in_expect(in_expect), .out_valid(out_valid), .out_fault(out_fault),
    .out_pure(out_pure), .out_extra(out_extra),
    .fault_count(fault_count), .pure_count(pure_count)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; in_state = '0; in_expect = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    m_primed = 0; m_ref = '0; m_fcnt = 0; m_pcnt = 0;
    @(negedge clk);
  endtask

  // Drive one operation at a negedge; return at the next negedge with the verdict visible.
  task automatic apply(input logic [SW-1:0] st, input logic [SW-1:0] ex,
                       output bit judged, output bit f, output bit p,
                       output logic [SW-1:0] x);
    logic [SW-1:0] obs;
    obs = st ^ m_ref;
    judged = m_primed;
    f = judged && (obs != ex);
    p = f && ((ex & ~obs) == '0);
    x = judged ? (obs & ~ex) : '0;
    if (f && m_fcnt < CMAX) m_fcnt++;
    if (p && m_pcnt < CMAX) m_pcnt++;
    m_ref = st; m_primed = 1;
    in_valid = 1; in_state = st; in_expect = ex;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic op_check(input string req, input logic [SW-1:0] st,
                          input logic [SW-1:0] ex);
    bit j, f, p; logic [SW-1:0] x;
    apply(st, ex, j, f, p, x);
    check(req, "out_valid", out_valid, j);
    check(req, "out_fault", out_fault, f);
    check(req, "out_pure", out_pure, p);
    check(req, "out_extra", out_extra, x);
  endtask

  task automatic t_reset();
    rst = 1; in_valid = 0; in_state = '0; in_expect = '0;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", out_valid, 0);
    check("R1", "fault_count in reset", fault_count, 0);
    rst = 0;
    m_primed = 0; m_ref = '0; m_fcnt = 0; m_pcnt = 0;
    @(negedge clk);
    check("R1", "flags after reset", {out_fault, out_pure}, 0);
    check("R1", "extra after reset", out_extra, 0);
    check("R1", "pure_count after reset", pure_count, 0);
  endtask

  task automatic t_prime();
    op_check("R2", 16'h1234, 16'hFFFF);
    check("R2", "fault_count after prime", fault_count, 0);
  endtask

  task automatic t_clean();
    op_check("R3", 16'h1235, 16'h0001);
    op_check("R4", 16'hEDCA, 16'hFFFF);
  endtask

  task automatic t_single_extra();
    op_check("R6", 16'hEDCA ^ 16'h0003, 16'h0001);
  endtask

  task automatic t_missing();
    op_check("R5", 16'h5A00, 16'h0000);
    op_check("R5", 16'h5A30, 16'h00F0);
  endtask

  task automatic t_mixed();
    op_check("R6", 16'h5A30 ^ 16'h0103, 16'h000F);
  endtask

  task automatic t_idle();
    logic [SW-1:0] keep;
    keep = m_ref;
    @(negedge clk);
    in_valid = 0; in_state = 16'hBEEF; in_expect = 16'hFFFF;
    @(negedge clk);
    check("R9", "valid idle", out_valid, 0);
    check("R9", "flags idle", {out_fault, out_pure}, 0);
    check("R9", "extra idle", out_extra, 0);
    op_check("R9", keep ^ 16'h0080, 16'h0080);
  endtask

  task automatic t_counts();
    check("R7", "fault_count", fault_count, m_fcnt);
    check("R8", "pure_count", pure_count, m_pcnt);
  endtask

  task automatic t_saturate();
    bit j, f, p; logic [SW-1:0] x;
    for (int i = 0; i < CMAX + 6; i++) begin
      // back-to-back: valid stays high across iterations (apply drops it only between)
      in_valid = 1;
      in_state = m_ref ^ 16'h8000; in_expect = '0;
      m_ref = in_state;
      if (m_fcnt < CMAX) m_fcnt++;
      if (m_pcnt < CMAX) m_pcnt++;
      @(negedge clk);
    end
    in_valid = 0;
    check("R7", "fault flag at saturation", out_fault, 1);
    check("R8", "pure flag at saturation", out_pure, 1);
    check("R6", "extra at saturation", out_extra, 16'h8000);
    check("R7", "fault_count saturated", fault_count, CMAX);
    check("R8", "pure_count saturated", pure_count, CMAX);
    op_check("R7", m_ref ^ 16'h0001, 16'h0002);
    check("R7", "fault_count held", fault_count, CMAX);
  endtask

  task automatic t_reset_mid();
    do_reset();
    check("R1", "fault_count after re-reset", fault_count, 0);
    op_check("R2", 16'h0F0F, 16'h0000);
    op_check("R4", 16'h0F0E, 16'h0001);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_prime();
    t_clean();
    t_single_extra();
    t_missing();
    t_mixed();
    t_idle();
    t_counts();
    t_saturate();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule